// File: doc/BRIEF.md
# Sync-Paced Element Transfer Sequencer

This block paces one side of a DMA channel against a peripheral's request line. Once started, it holds a latched copy of its configuration: the sync granularity, the elements per frame, the frames per block, the elements per packet and a signed repeat count. Each sync event then releases a run of element strobes to the datapath. Each strobe is a request that stays high until the datapath acknowledges it. The granularity sets how many elements one sync event releases: a single element, a frame, a whole block, or a packet. In packet mode, a packet that reaches the end of the block is cut short. With the "none" setting, the whole sequence runs as soon as it is started.

Sync events that arrive while a run is in progress are queued in a small counter and served in order. If the counter is full, a sticky overflow flag is set. One-cycle pulses mark the end of each frame, each block and, when enabled, each repeated pass. An abort returns the sequencer to idle at the next edge and drops every queued sync.

Top module: `sync_xfer_seq`

## Requirements
- R1: With granularity code 1 (element), each sync event releases exactly one element handshake.
- R2: With code 2 (frame), each sync event releases the elements-per-frame count of handshakes.
- R3: With code 3 (block), each sync event releases elements-per-frame times frames-per-block handshakes.
- R4: With code 4 (packet), each sync event releases the elements-per-packet count. A packet that reaches the end of a block holds only the elements that remain in that block, and the next pass starts a fresh packet.
- R5: A repeat count of 0 gives one pass and a count n > 0 gives n+1 passes. A negative count (-1) repeats without end until abort. `busy` falls on the edge that completes the final element.
- R6: `frame_done` pulses once per finished frame and `block_done` pulses once per finished block, one cycle after the completing handshake.
- R7: `repeat_done` pulses with each `block_done` when `cfg_rpt_note` was set at start and the repeat count is non-zero; otherwise it never pulses.
- R8: Sync events seen while busy are queued and served in order, up to 15 pending. A sync that arrives with 15 already pending sets `ovf_err`, which stays set until the next start or abort. Sync events seen while idle are ignored.
- R9: After `abort`, `busy` and `xfer_req` are low at the next edge and no queued sync is served afterwards.
- R10: With code 0 (none), the whole sequence of all passes runs after `start` without any sync event.
- R11: After reset, `busy`, `xfer_req`, `frame_done`, `block_done`, `repeat_done` and `ovf_err` are low.
- R12: `xfer_req` stays high until `xfer_ack` is seen. Each cycle with both high completes one element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration and begin (honoured when idle) |
| abort | input | 1 | Return to idle, drop queued syncs |
| cfg_gran | input | 3 | Granularity: 0 none, 1 element, 2 frame, 3 block, 4 packet |
| cfg_epf | input | EW | Elements per frame (non-zero) |
| cfg_fpt | input | FW | Frames per block (non-zero) |
| cfg_epp | input | EW | Elements per packet (non-zero) |
| cfg_rep | input | RW | Signed repeat count, negative means endless |
| cfg_rpt_note | input | 1 | Enable per-pass notification |
| sync_req | input | 1 | Peripheral sync event, one per high cycle |
| xfer_req | output | 1 | Element transfer request |
| xfer_ack | input | 1 | Datapath acknowledge |
| frame_done | output | 1 | Frame finished pulse |
| block_done | output | 1 | Block finished pulse |
| repeat_done | output | 1 | Pass finished pulse (when enabled) |
| busy | output | 1 | Sequence in progress |
| ovf_err | output | 1 | Sticky sync queue overflow |

## Verification
Random cases draw the granularity, frame, block, packet and repeat sizes, and the acknowledge timing is also random. Each sync is issued alone, so a wrong run length shows up as a mismatch in that run's element count. Packet sizes that do not divide the block expose a final packet that is not cut short, and multi-pass cases expose packet state that leaks across a block boundary. Directed cases hold back the acknowledge to fill the sync queue past its depth, check the element count served afterwards, abort an endless block run with syncs still queued, and offer a sync while idle.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
   typedef enum logic [2:0] {
      GR_NONE   = 3'd0,
      GR_ELEM   = 3'd1,
      GR_FRAME  = 3'd2,
      GR_BLOCK  = 3'd3,
      GR_PACKET = 3'd4
   } gran_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sxs_pend_ctr.sv
module sxs_pend_ctr #(
   parameter int PEND_MAX = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sync_in,
   input  logic take,
   output logic has_pend,
   output logic ovf
);
   localparam int PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] CMAX = PW'(PEND_MAX);

   initial assert (PEND_MAX >= 1) else $error("PEND_MAX must be at least 1");

   logic [PW-1:0] cnt;
   logic          dec;

   assign dec      = take && (cnt != '0);
   assign has_pend = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (sync_in && !dec) begin
         if (cnt == CMAX) ovf <= 1'b1;
         else             cnt <= cnt + PW'(1);
      end else if (!sync_in && dec) begin
         cnt <= cnt - PW'(1);
      end
   end

   // R8
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in && !take && !clr && cnt == CMAX) |=> ovf);
endmodule

// File: rtl/sxs_nest_ctr.sv
module sxs_nest_ctr #(
   parameter int EW     = 8,
   parameter int FW     = 8,
   parameter int RW     = 8,
   parameter bit PKT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic [EW-1:0] epf,
   input  logic [FW-1:0] fpt,
   input  logic [EW-1:0] epp,
   input  logic [RW-1:0] rep,
   output logic          last_elem,
   output logic          last_frame,
   output logic          last_pkt,
   output logic          final_pass
);
   logic [EW-1:0] ecnt;
   logic [FW-1:0] fcnt;
   logic [RW-1:0] rcnt;
   logic          blk_end;

   assign last_elem  = (ecnt == epf - EW'(1));
   assign last_frame = (fcnt == fpt - FW'(1));
   assign blk_end    = last_elem && last_frame;
   assign final_pass = !rep[RW-1] && (rcnt == rep);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt <= '0;
         fcnt <= '0;
         rcnt <= '0;
      end else if (load) begin
         ecnt <= '0;
         fcnt <= '0;
         rcnt <= '0;
      end else if (adv) begin
         if (last_elem) begin
            ecnt <= '0;
            if (last_frame) begin
               fcnt <= '0;
               rcnt <= rcnt + RW'(1);
            end else begin
               fcnt <= fcnt + FW'(1);
            end
         end else begin
            ecnt <= ecnt + EW'(1);
         end
      end
   end

   generate
      if (PKT_EN) begin : g_pkt
         logic [EW-1:0] pcnt;
         assign last_pkt = (pcnt == epp - EW'(1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pcnt <= '0;
            else if (load)  pcnt <= '0;
            else if (adv)   pcnt <= (blk_end || last_pkt) ? '0 : pcnt + EW'(1);
         end
      end else begin : g_nopkt
         assign last_pkt = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sync_xfer_seq.sv
module sync_xfer_seq
   import sxs_pkg::*;
#(
   parameter int EW       = 8,
   parameter int FW       = 8,
   parameter int RW       = 8,
   parameter int PEND_MAX = 15,
   parameter bit PKT_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic [2:0]    cfg_gran,
   input  logic [EW-1:0] cfg_epf,
   input  logic [FW-1:0] cfg_fpt,
   input  logic [EW-1:0] cfg_epp,
   input  logic [RW-1:0] cfg_rep,
   input  logic          cfg_rpt_note,
   input  logic          sync_req,
   output logic          xfer_req,
   input  logic          xfer_ack,
   output logic          frame_done,
   output logic          block_done,
   output logic          repeat_done,
   output logic          busy,
   output logic          ovf_err
);
   initial assert (EW >= 2 && FW >= 1 && RW >= 2) else $error("bad width parameters");

   seq_st_e       st;
   gran_e         gran_q;
   logic [EW-1:0] epf_q, epp_q;
   logic [FW-1:0] fpt_q;
   logic [RW-1:0] rep_q;
   logic          note_q;

   logic go, take, has_pend, ack_ev, blk_end, burst_end;
   logic last_elem, last_frame, last_pkt, final_pass;

   assign go       = start && (st == ST_IDLE) && !abort;
   assign take     = (st == ST_WAIT) && has_pend && !abort;
   assign ack_ev   = (st == ST_XFER) && xfer_ack && !abort;
   assign blk_end  = last_elem && last_frame;
   assign xfer_req = (st == ST_XFER);
   assign busy     = (st != ST_IDLE);

   always_comb begin
      unique case (gran_q)
         GR_ELEM:   burst_end = 1'b1;
         GR_FRAME:  burst_end = last_elem;
         GR_PACKET: burst_end = last_pkt || blk_end;
         default:   burst_end = blk_end;
      endcase
   end

   sxs_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (abort || go),
      .sync_in  (sync_req && busy && !abort),
      .take     (take),
      .has_pend (has_pend),
      .ovf      (ovf_err)
   );

   sxs_nest_ctr #(.EW(EW), .FW(FW), .RW(RW), .PKT_EN(PKT_EN)) u_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (go),
      .adv        (ack_ev),
      .epf        (epf_q),
      .fpt        (fpt_q),
      .epp        (epp_q),
      .rep        (rep_q),
      .last_elem  (last_elem),
      .last_frame (last_frame),
      .last_pkt   (last_pkt),
      .final_pass (final_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         gran_q <= GR_NONE;
         epf_q  <= EW'(1);
         fpt_q  <= FW'(1);
         epp_q  <= EW'(1);
         rep_q  <= '0;
         note_q <= 1'b0;
      end else if (abort) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_IDLE: if (go) begin
               gran_q <= gran_e'(cfg_gran);
               epf_q  <= cfg_epf;
               fpt_q  <= cfg_fpt;
               epp_q  <= cfg_epp;
               rep_q  <= cfg_rep;
               note_q <= cfg_rpt_note;
               st     <= (gran_e'(cfg_gran) == GR_NONE) ? ST_XFER : ST_WAIT;
            end
            ST_WAIT: if (take) st <= ST_XFER;
            ST_XFER: if (ack_ev) begin
               if (blk_end && final_pass)                st <= ST_IDLE;
               else if (burst_end && gran_q != GR_NONE)  st <= ST_WAIT;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_done  <= 1'b0;
         block_done  <= 1'b0;
         repeat_done <= 1'b0;
      end else begin
         frame_done  <= ack_ev && last_elem;
         block_done  <= ack_ev && blk_end;
         repeat_done <= ack_ev && blk_end && note_q && (rep_q != '0);
      end
   end

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack && !abort) |=> xfer_req);
   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !xfer_req));
   // R6
   blk_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |-> frame_done);
   // R7
   rep_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repeat_done |-> block_done);
   // R10
   none_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && gran_q == GR_NONE) |-> (st != ST_WAIT));
endmodule

// File: tb/sim_sync_xfer_seq.sv
`timescale 1ns/1ps
module sim_sync_xfer_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, abort = 1'b0, sync_req = 1'b0, xfer_ack = 1'b0;
   logic [2:0] cfg_gran = 3'd0;
   logic [7:0] cfg_epf = 8'd1, cfg_fpt = 8'd1, cfg_epp = 8'd1, cfg_rep = 8'd0;
   logic       cfg_rpt_note = 1'b0;
   logic       xfer_req, frame_done, block_done, repeat_done, busy, ovf_err;

   int  n_chk = 0, n_bad = 0;
   int  n_elem = 0, n_frm = 0, n_blk = 0, n_rpt = 0;
   bit  ack_en = 1'b0;
   bit  done_flag = 1'b0;

   always #2 clk = ~clk;

   sync_xfer_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .cfg_gran(cfg_gran), .cfg_epf(cfg_epf), .cfg_fpt(cfg_fpt),
      .cfg_epp(cfg_epp), .cfg_rep(cfg_rep), .cfg_rpt_note(cfg_rpt_note),
      .sync_req(sync_req), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
      .frame_done(frame_done), .block_done(block_done),
      .repeat_done(repeat_done), .busy(busy), .ovf_err(ovf_err)
   );

   always @(posedge clk) begin
      if (xfer_req && xfer_ack && !abort) n_elem <= n_elem + 1;
      if (frame_done)  n_frm <= n_frm + 1;
      if (block_done)  n_blk <= n_blk + 1;
      if (repeat_done) n_rpt <= n_rpt + 1;
   end

   always @(negedge clk) xfer_ack <= ack_en && ($urandom_range(0, 3) != 0);

   task automatic chk(input int got, input int exp, input string tag);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_req = 1'b1;
      @(negedge clk) sync_req = 1'b0;
   endtask

   task automatic do_start(input int g, input int epf, input int fpt, input int epp,
                           input int rep, input bit note);
      @(negedge clk);
      cfg_gran = 3'(g); cfg_epf = 8'(epf); cfg_fpt = 8'(fpt);
      cfg_epp = 8'(epp); cfg_rep = 8'(rep); cfg_rpt_note = note;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // one sync event, then wait for the run to go quiet
   task automatic do_burst(input int exp, input string tag);
      int base, quiet;
      bit seen;
      base = n_elem; quiet = 0; seen = 1'b0;
      pulse_sync();
      while (!(seen && quiet >= 3)) begin
         @(negedge clk);
         if (xfer_req) begin seen = 1'b1; quiet = 0; end
         else quiet++;
      end
      chk(n_elem - base, exp, tag);
   endtask

   function automatic int burst_len(input int g, input int epf, input int tot,
                                    input int epp, input int pos);
      case (g)
         1: return 1;
         2: return epf;
         3: return tot;
         default: return (epp < tot - pos) ? epp : tot - pos;
      endcase
   endfunction

   task automatic run_case(input int g, input int epf, input int fpt, input int epp,
                           input int rep, input bit note);
      int e0, f0, b0, r0, tot, passes;
      string tag;
      e0 = n_elem; f0 = n_frm; b0 = n_blk; r0 = n_rpt;
      tot = epf * fpt; passes = rep + 1;
      tag = (g == 1) ? "R1" : (g == 2) ? "R2" : (g == 3) ? "R3" : "R4";
      do_start(g, epf, fpt, epp, rep, note);
      if (g == 0) begin
         while (busy) @(negedge clk);
         repeat (2) @(negedge clk);
         chk(n_elem - e0, tot * passes, "R10 total elements without sync");
      end else begin
         for (int p = 0; p < passes; p++) begin
            int pos = 0;
            while (pos < tot) begin
               int sz = burst_len(g, epf, tot, epp, pos);
               do_burst(sz, tag);
               pos += sz;
            end
         end
      end
      chk(int'(busy), 0, "R5 busy low after final pass");
      chk(n_elem - e0, tot * passes, "R5 elements over all passes");
      chk(n_frm - f0, fpt * passes, "R6 frame pulses");
      chk(n_blk - b0, passes, "R6 block pulses");
      chk(n_rpt - r0, (note && rep != 0) ? passes : 0, "R7 repeat pulses");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      int sd;
      sd = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(int'(busy), 0, "R11 busy");
      chk(int'(xfer_req), 0, "R11 xfer_req");
      chk(int'(frame_done | block_done | repeat_done), 0, "R11 pulses");
      chk(int'(ovf_err), 0, "R11 ovf_err");
      rst_n = 1'b1;
      ack_en = 1'b1;

      // R8 sync while idle is ignored
      pulse_sync();
      do_start(1, 4, 1, 1, 0, 1'b0);
      repeat (8) @(negedge clk);
      chk(n_elem, 0, "R8 idle sync ignored");
      for (int i = 0; i < 4; i++) do_burst(1, "R1");
      chk(int'(busy), 0, "R5 single pass ends");

      // directed corners
      run_case(4, 3, 3, 4, 1, 1'b1);   // R4 short final packet, two passes
      run_case(4, 5, 1, 5, 0, 1'b0);   // R4 exact packet
      run_case(2, 3, 2, 1, 2, 1'b1);   // R2
      run_case(3, 2, 3, 1, 1, 1'b0);   // R3
      run_case(0, 3, 2, 1, 1, 1'b1);   // R10

      // random cases
      for (int k = 0; k < 30; k++) begin
         int g = $urandom_range(0, 4);
         run_case(g, $urandom_range(1, 4), $urandom_range(1, 3),
                  $urandom_range(1, 5), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
      end

      // R8 queue fill and overflow, served in order
      begin
         int e0;
         e0 = n_elem;
         ack_en = 1'b0;
         do_start(1, 4, 4, 1, 0, 1'b0);
         for (int i = 0; i < 17; i++) pulse_sync();
         chk(int'(ovf_err), 1, "R8 overflow flag set");
         chk(n_elem - e0, 0, "R12 no element without ack");
         chk(int'(xfer_req), 1, "R12 request held");
         ack_en = 1'b1;
         repeat (80) @(negedge clk);
         chk(n_elem - e0, 16, "R8 queued syncs served");
         chk(int'(busy), 0, "R8 block finished from queue");
         chk(int'(ovf_err), 1, "R8 overflow sticky");
         do_start(1, 2, 1, 1, 0, 1'b0);
         chk(int'(ovf_err), 0, "R8 overflow cleared by start");
      end

      // R5 endless block mode, then R9 abort with syncs queued
      begin
         int b0, e0;
         @(negedge clk) abort = 1'b1;
         @(negedge clk) abort = 1'b0;
         b0 = n_blk;
         do_start(3, 2, 2, 1, -1, 1'b1);
         for (int i = 0; i < 3; i++) do_burst(4, "R3");
         chk(n_blk - b0, 3, "R5 endless passes");
         chk(int'(busy), 1, "R5 endless stays busy");
         ack_en = 1'b0;
         pulse_sync();
         pulse_sync();
         pulse_sync();
         @(negedge clk) abort = 1'b1;
         @(negedge clk) abort = 1'b0;
         chk(int'(busy), 0, "R9 busy low after abort");
         chk(int'(xfer_req), 0, "R9 request low after abort");
         ack_en = 1'b1;
         e0 = n_elem;
         do_start(1, 3, 1, 1, 0, 1'b0);
         repeat (10) @(negedge clk);
         chk(n_elem - e0, 0, "R9 queued syncs dropped");
         do_burst(1, "R1 after abort");
      end

      summary();
   end
endmodule